// File: doc/BRIEF.md
# Bus Tenure Release Timer

This block sits beside a DMA bus master and bounds how long that master holds the system bus. Each bus grant starts a new tenure. During it, two down-counters run: one counts timebase ticks and one counts completed transfers. When limiting is enabled and either budget runs out, the block raises a release request. The request tells the master's sequencer to finish its current transfer and hand the bus back.

Software programs the two budgets through a small host port. The port accepts writes only while the controller is stopped. A test mode turns each accepted write into a write followed by one decrement, so the decrement path can be exercised without running a tenure. The arbitration handshake and the transfer sequencing belong to other blocks. This block only observes the grant level, a tick enable and a per-transfer strobe.

Top module: `busTenureTimer`

## Requirements
- R1: After reset both budget registers read back as zero and `busRelease` is low.
- R2: A host write (`hostWr` high) changes a budget register only while `stopped` is high. `hostSel` 0 selects the time budget and 1 selects the transfer budget. While `stopped` is high, `hostRdData` shows the selected register. While `stopped` is low, it reads zero.
- R3: With `testMode` high, an accepted write stores the written value minus one, modulo 2^CW (0 becomes all ones).
- R4: A rising edge of `grant` reloads both counters from their registers. A tick or transfer strobe in that same cycle is not counted.
- R5: Ticks are counted only while the grant is held. `busRelease` rises in the cycle after the max(T,1)-th counted tick, where T is the time budget.
- R6: Transfer strobes are counted only while the grant is held. `busRelease` rises in the cycle after the max(X,1)-th counted transfer, where X is the transfer budget, so a budget of zero releases after the first transfer.
- R7: When both budgets are running, `busRelease` rises after whichever limit is reached first.
- R8: Once high, `busRelease` stays high while the grant is held, even with no further events. It falls in the cycle after `grant` drops.
- R9: While `limitEnable` is low, `busRelease` is never high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stopped | input | 1 | Controller stopped; gates host access |
| hostWr | input | 1 | Host write strobe |
| hostSel | input | 1 | Register select: 0 time budget, 1 transfer budget |
| hostWrData | input | CW | Host write data |
| hostRdData | output | CW | Host read data |
| testMode | input | 1 | Writes also decrement |
| limitEnable | input | 1 | Enables the release request |
| grant | input | 1 | Bus granted to the master |
| tick | input | 1 | Timebase tick enable |
| xferStrobe | input | 1 | One pulse per completed transfer |
| busRelease | output | 1 | Request to give up the bus |

## Verification
The assertions assume that `grant` is a level that stays high for the whole tenure, and that host writes do not coincide with the first cycle of a grant. The bench drives every input on the falling clock edge. It programs the budgets only while the grant is low and the controller is stopped. It raises the grant only after leaving the stopped state, and it keeps events out of the grant cycle except in the one case that checks they are ignored.

// File: rtl/busTenurePkg.sv
package busTenurePkg;
  typedef struct packed {
    logic load;     // reload counters from budget registers
    logic timeDec;  // count one timebase tick
    logic xferDec;  // count one transfer
  } tenureStrobeT;
endpackage

// File: rtl/tenureDatapath.sv
module tenureDatapath
  import busTenurePkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          stopped,
  input  logic          hostWr,
  input  logic          hostSel,
  input  logic [CW-1:0] hostWrData,
  input  logic          testMode,
  output logic [CW-1:0] hostRdData,
  input  tenureStrobeT  strobes,
  output logic          timeLast,
  output logic          xferLast
);
  localparam logic [CW-1:0] One = CW'(1);

  logic [CW-1:0] budgetReg [2];
  logic [CW-1:0] countReg  [2];
  logic [CW-1:0] wrValue;
  logic          decStrobe [2];

  assign wrValue      = testMode ? hostWrData - One : hostWrData;
  assign decStrobe[0] = strobes.timeDec;
  assign decStrobe[1] = strobes.xferDec;

  for (genvar g = 0; g < 2; g++) begin : gLane
    always_ff @(posedge clk) begin
      if (!rstN) begin
        budgetReg[g] <= '0;
      end else if (stopped && hostWr && (hostSel == 1'(g))) begin
        budgetReg[g] <= wrValue;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        countReg[g] <= '0;
      end else if (strobes.load) begin
        countReg[g] <= budgetReg[g];
      end else if (decStrobe[g] && (countReg[g] != '0)) begin
        countReg[g] <= countReg[g] - One;
      end
    end

    // counter only ever moves down between reloads
    assert_count_down_R5: assert property (@(posedge clk) disable iff (!rstN)
      !strobes.load |=> countReg[g] <= $past(countReg[g]));
  end

  assign timeLast   = countReg[0] <= One;
  assign xferLast   = countReg[1] <= One;
  assign hostRdData = stopped ? budgetReg[hostSel] : '0;

  assert_locked_regs_R2: assert property (@(posedge clk) disable iff (!rstN)
    !stopped |=> ($stable(budgetReg[0]) && $stable(budgetReg[1])));

  assert_reload_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && !(stopped && hostWr)) |=> countReg[0] == $past(budgetReg[0]));
endmodule

// File: rtl/tenureControl.sv
module tenureControl
  import busTenurePkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         grant,
  input  logic         tick,
  input  logic         xferStrobe,
  input  logic         limitEnable,
  input  logic         timeLast,
  input  logic         xferLast,
  output tenureStrobeT strobes,
  output logic         busRelease
);
  logic grantQ;
  logic held;
  logic limitHit;
  logic releaseQ;

  assign held            = grant && grantQ;
  assign strobes.load    = grant && !grantQ;
  assign strobes.timeDec = held && tick;
  assign strobes.xferDec = held && xferStrobe;
  assign limitHit        = (strobes.timeDec && timeLast) || (strobes.xferDec && xferLast);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantQ   <= 1'b0;
      releaseQ <= 1'b0;
    end else begin
      grantQ <= grant;
      if (!grant || !limitEnable) begin
        releaseQ <= 1'b0;
      end else if (limitHit) begin
        releaseQ <= 1'b1;
      end
    end
  end

  assign busRelease = releaseQ && limitEnable;

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busRelease && grant && limitEnable) |=> (busRelease || !limitEnable));

  assert_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    !grant |=> !busRelease);

  assert_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busRelease) |-> ($past(timeLast && tick && grant) || $past(xferLast && xferStrobe && grant)));

  assert_enable_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    !limitEnable |-> !busRelease);
endmodule

// File: rtl/busTenureTimer.sv
module busTenureTimer
  import busTenurePkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          stopped,
  input  logic          hostWr,
  input  logic          hostSel,
  input  logic [CW-1:0] hostWrData,
  output logic [CW-1:0] hostRdData,
  input  logic          testMode,
  input  logic          limitEnable,
  input  logic          grant,
  input  logic          tick,
  input  logic          xferStrobe,
  output logic          busRelease
);
  tenureStrobeT strobes;
  logic         timeLast;
  logic         xferLast;

  tenureDatapath #(.CW(CW)) uData (
    .clk(clk), .rstN(rstN), .stopped(stopped), .hostWr(hostWr),
    .hostSel(hostSel), .hostWrData(hostWrData), .testMode(testMode),
    .hostRdData(hostRdData), .strobes(strobes),
    .timeLast(timeLast), .xferLast(xferLast)
  );

  tenureControl uCtrl (
    .clk(clk), .rstN(rstN), .grant(grant), .tick(tick),
    .xferStrobe(xferStrobe), .limitEnable(limitEnable),
    .timeLast(timeLast), .xferLast(xferLast),
    .strobes(strobes), .busRelease(busRelease)
  );
endmodule

// File: tb/tb_busTenureTimer.sv
module tb_busTenureTimer;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          stopped = 1'b1;
  logic          hostWr = 1'b0;
  logic          hostSel = 1'b0;
  logic [CW-1:0] hostWrData = '0;
  logic [CW-1:0] hostRdData;
  logic          testMode = 1'b0;
  logic          limitEnable = 1'b1;
  logic          grant = 1'b0;
  logic          tick = 1'b0;
  logic          xferStrobe = 1'b0;
  logic          busRelease;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  busTenureTimer #(.CW(CW)) dut (.*);

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic hostWrite(input logic sel, input int value);
    hostSel = sel; hostWrData = CW'(value); hostWr = 1'b1;
    step();
    hostWr = 1'b0;
  endtask

  task automatic readReg(input logic sel, output int value);
    hostSel = sel;
    #1 value = int'(hostRdData);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int rd;
    @(negedge clk); step(); rstN = 1'b1; step();

    // R1 reset state
    readReg(1'b0, rd); check("R1 time reg", rd, 0);
    readReg(1'b1, rd); check("R1 xfer reg", rd, 0);
    check("R1 release", int'(busRelease), 0);

    // R2 gating of writes and reads
    hostWrite(1'b0, 9);
    stopped = 1'b0;
    hostWrite(1'b0, 85);
    readReg(1'b0, rd); check("R2 read while running", rd, 0);
    stopped = 1'b1;
    readReg(1'b0, rd); check("R2 write ignored while running", rd, 9);

    // R3 test mode decrement on write
    testMode = 1'b1;
    hostWrite(1'b1, 5);
    readReg(1'b1, rd); check("R3 decrement", rd, 4);
    hostWrite(1'b0, 0);
    readReg(1'b0, rd); check("R3 wrap", rd, 255);
    testMode = 1'b0;

    // R5 R6 R7 sweep over both budgets and three event patterns
    for (int t = 0; t <= 6; t++) begin
      for (int x = 0; x <= 6; x++) begin
        for (int mode = 0; mode < 3; mode++) begin
          int needT, needX, need;
          stopped = 1'b1;
          hostWrite(1'b0, t);
          hostWrite(1'b1, x);
          readReg(1'b0, rd); check("R2 time readback", rd, t);
          readReg(1'b1, rd); check("R2 xfer readback", rd, x);
          stopped = 1'b0;
          needT = (t < 1) ? 1 : t;
          needX = (x < 1) ? 1 : x;
          need  = (mode == 0) ? needT : (mode == 1) ? needX : ((needT < needX) ? needT : needX);
          grant = 1'b1;
          step();
          for (int n = 1; n <= 8; n++) begin
            tick       = (mode != 1);
            xferStrobe = (mode != 0);
            step();
            tick = 1'b0; xferStrobe = 1'b0;
            check(mode == 0 ? "R5 time budget" : mode == 1 ? "R6 transfer budget" : "R7 first limit",
                  int'(busRelease), (n >= need) ? 1 : 0);
          end
          step();
          check("R8 held without events", int'(busRelease), 1);
          grant = 1'b0;
          step();
          check("R8 falls after grant", int'(busRelease), 0);
        end
      end
    end

    // R4 event in the grant cycle is ignored
    stopped = 1'b1;
    hostWrite(1'b0, 2);
    hostWrite(1'b1, 50);
    stopped = 1'b0;
    grant = 1'b1; tick = 1'b1;
    step();
    tick = 1'b0;
    check("R4 grant cycle tick", int'(busRelease), 0);
    tick = 1'b1; step(); tick = 1'b0;
    check("R4 one counted tick", int'(busRelease), 0);
    tick = 1'b1; step(); tick = 1'b0;
    check("R4 two counted ticks", int'(busRelease), 1);
    grant = 1'b0; step();

    // R5 ticks outside a grant are not counted
    tick = 1'b1; step(); step(); tick = 1'b0;
    grant = 1'b1; step();
    tick = 1'b1; step(); tick = 1'b0;
    check("R5 no count outside grant", int'(busRelease), 0);
    grant = 1'b0; step();

    // R9 enable clear blocks release
    limitEnable = 1'b0;
    grant = 1'b1; step();
    for (int n = 0; n < 5; n++) begin
      tick = 1'b1; xferStrobe = 1'b1; step();
      check("R9 disabled", int'(busRelease), 0);
    end
    tick = 1'b0; xferStrobe = 1'b0;
    grant = 1'b0; step();
    limitEnable = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule